// File: doc/BRIEF.md
# Vertical Mode Channel Switch Controller

This block drives the four control lines of a two-input analog channel switch in a dual-trace display. The switch presents channel 1, channel 2, or the sum of the two. The block decides which of these is shown from a three-bit display-mode input. The modes are:

- channel 1 alone
- channel 2 alone
- sum
- alternate, where the channel changes once per sweep
- chop, where the channel changes at a fixed high rate within a sweep

Two toggle registers hold the switch state. In the three fixed modes both registers are loaded with a constant pattern, and no event moves them. In alternate mode the registers flip on each rising edge of the sweep-end sync input, which is asynchronous. In chop mode a divider on the system clock produces a tick at `CHOP_HZ` (2 MHz by default), and each tick flips the registers. A channel therefore stays on screen for half a microsecond, so the two channels repeat at 1 MHz. The divider only counts while chop mode is in force. On every chop changeover the block raises a one-clock `chop_blank` pulse, which lets the display be blanked while the switch settles.

The block has no data stream, so every pin is a plain level. `sw_ctrl` bit 3 is line A, bit 2 is line B, bit 1 is line C and bit 0 is line D.

Top module: `vert_chan_switch`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `sw_ctrl` = 4'b1010 and `chop_blank` = 0.
- R2: `mode_sel` encodings are 0 = channel 1, 1 = channel 2, 2 = sum, 3 = alternate, 4 = chop, and 5..7 = channel 1. One edge after a fixed mode is applied, `sw_ctrl` holds 4'b1010 for channel 1, 4'b0101 for channel 2 and 4'b1100 for sum.
- R3: In a fixed mode, `sw_ctrl` stays constant for as long as the mode is held, whatever `alt_sync` does.
- R4: On the first edge at which `mode_sel` becomes alternate or chop, `sw_ctrl` is loaded with 4'b1010, whatever the previous code was.
- R5: In alternate mode, each rising edge of `alt_sync` swaps `sw_ctrl` between 4'b1010 and 4'b0101 exactly once, whatever the width of the pulse. The swap is visible after the third clock edge that samples `alt_sync` high.
- R6: In chop mode, counting from the entry edge, `sw_ctrl` swaps between 4'b1010 and 4'b0101 after every `DIV` = `CLK_HZ`/`CHOP_HZ` edges. `alt_sync` has no effect in this mode.
- R7: `chop_blank` is high for exactly one clock, in the first cycle of each new code produced in chop mode, and is low in all other modes.
- R8: In alternate and chop modes, `sw_ctrl` never shows the sum code 4'b1100.
- R9: The chop divider is cleared whenever chop mode is left, so each new entry into chop gives its first swap a full `DIV` edges after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Display mode (encoding in R2) |
| alt_sync | input | 1 | Asynchronous sweep-end sync, rising edge active |
| sw_ctrl | output | 4 | Switch lines A..D on bits 3..0 |
| chop_blank | output | 1 | One-clock blanking pulse at each chop swap |

## Verification
The properties assume that `mode_sel` is synchronous to `clk` and stable across each edge. They also assume that `alt_sync` pulses are separated by at least three clocks of low level, since otherwise the synchronizer cannot observe distinct edges. The stimulus changes `mode_sel` only just after a falling clock edge. It keeps a gap of six or more clocks between alternate-mode pulses, and it never lets a sync edge coincide with a mode change into alternate mode.

// File: rtl/vms_pkg.sv
package vms_pkg;

  typedef enum logic [2:0] {
    VM_CH1  = 3'd0,
    VM_CH2  = 3'd1,
    VM_SUM  = 3'd2,
    VM_ALT  = 3'd3,
    VM_CHOP = 3'd4
  } vmode_e;

  // Register pair state: {first, second}
  localparam logic [1:0] PAIR_CH1 = 2'b10;
  localparam logic [1:0] PAIR_CH2 = 2'b01;
  localparam logic [1:0] PAIR_SUM = 2'b11;

  function automatic logic is_swapping(input logic [2:0] m);
    return (m == VM_ALT) || (m == VM_CHOP);
  endfunction

  // Fixed-mode pattern; unused encodings fall back to channel 1
  function automatic logic [1:0] fixed_pair(input logic [2:0] m);
    logic [1:0] r;
    case (m)
      VM_CH2:  r = PAIR_CH2;
      VM_SUM:  r = PAIR_SUM;
      default: r = PAIR_CH1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vms_chop_div.sv
module vms_chop_div #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  // Held at zero whenever chop is not running
  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vms_sync_edge.sv
module vms_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/vms_ff_pair.sv
module vms_ff_pair (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] load_val,
  input  logic       flip,
  output logic [1:0] q
);
  // Two toggle registers: loaded in fixed modes, flipped by the selected clock source
  for (genvar g = 0; g < 2; g++) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst)       q[g] <= vms_pkg::PAIR_CH1[g];
      else if (load) q[g] <= load_val[g];
      else if (flip) q[g] <= ~q[g];
    end
  end
endmodule

// File: rtl/vert_chan_switch.sv
module vert_chan_switch #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int CHOP_HZ     = 2_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_sel,
  input  logic       alt_sync,
  output logic [3:0] sw_ctrl,
  output logic       chop_blank
);
  import vms_pkg::*;

  localparam int DIV = CLK_HZ / CHOP_HZ;

  logic [2:0] prev_mode;
  logic       mode_new;
  logic       in_alt, in_chop;
  logic       sync_rise, chop_tick;
  logic       load, flip;
  logic [1:0] load_val;
  logic [1:0] pair;

  always_ff @(posedge clk) begin
    if (rst) prev_mode <= VM_CH1;
    else     prev_mode <= mode_sel;
  end

  assign mode_new = (mode_sel != prev_mode);
  assign in_alt   = (mode_sel == VM_ALT)  && !mode_new;
  assign in_chop  = (mode_sel == VM_CHOP) && !mode_new;

  vms_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (alt_sync),
    .rise(sync_rise)
  );

  vms_chop_div #(.DIV(DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .run (in_chop),
    .tick(chop_tick)
  );

  assign load     = mode_new || !is_swapping(mode_sel);
  assign load_val = is_swapping(mode_sel) ? PAIR_CH1 : fixed_pair(mode_sel);
  assign flip     = (in_alt && sync_rise) || chop_tick;

  vms_ff_pair u_pair (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .flip    (flip),
    .q       (pair)
  );

  // Lines A..D from the two register outputs and their complements
  assign sw_ctrl = {pair[1], pair[0], ~pair[0], ~pair[1]};

  always_ff @(posedge clk) begin
    if (rst) chop_blank <= 1'b0;
    else     chop_blank <= chop_tick;
  end
endmodule

// File: rtl/vms_chk.sv
module vms_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_sel,
  input logic [3:0] sw_ctrl,
  input logic       chop_blank
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sw_ctrl == 4'b1010) && !chop_blank);

  // R2
  ch2_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd1) |=> (sw_ctrl == 4'b0101));

  // R2
  sum_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd2) |=> (sw_ctrl == 4'b1100));

  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel != 3'd3) && (mode_sel != 3'd4) && (mode_sel == $past(mode_sel)))
      |=> $stable(sw_ctrl));

  // R4
  entry_code_chk: assert property (@(posedge clk) disable iff (rst)
    (((mode_sel == 3'd3) || (mode_sel == 3'd4)) && (mode_sel != $past(mode_sel)))
      |=> (sw_ctrl == 4'b1010));

  // R7
  blank_in_chop_chk: assert property (@(posedge clk) disable iff (rst)
    chop_blank |-> ($past(mode_sel) == 3'd4) && (sw_ctrl != $past(sw_ctrl)));

  // R7
  blank_single_chk: assert property (@(posedge clk) disable iff (rst)
    chop_blank |=> !chop_blank);

  // R8
  no_sum_swap_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 3'd3) || (mode_sel == 3'd4)) |=> (sw_ctrl != 4'b1100));
endmodule

bind vert_chan_switch vms_chk i_vms_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sel  (mode_sel),
  .sw_ctrl   (sw_ctrl),
  .chop_blank(chop_blank)
);

// File: tb/test_vert_chan_switch.sv
module test_vert_chan_switch;
  localparam int CLK_HZ  = 20_000_000;
  localparam int CHOP_HZ = 2_000_000;
  localparam int DIV     = CLK_HZ / CHOP_HZ;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'd0;
  logic       alt_sync = 1'b0;
  logic [3:0] sw_ctrl;
  logic       chop_blank;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  vert_chan_switch #(.CLK_HZ(CLK_HZ), .CHOP_HZ(CHOP_HZ)) i_vert_chan_switch (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .alt_sync(alt_sync),
    .sw_ctrl(sw_ctrl), .chop_blank(chop_blank)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fixed_code(input int m);
    if (m == 1) return 4'b0101;
    if (m == 2) return 4'b1100;
    return 4'b1010;
  endfunction

  // Chop run from the entry edge: R4, R6, R7, R8, R9
  task automatic run_chop(input int cycles, input string req);
    mode_sel = 3'd4;
    step(1);
    check({req, " R4 entry"}, sw_ctrl, 4'b1010);
    for (int j = 1; j <= cycles; j++) begin
      alt_sync = (j % 7 == 3);  // R6: ignored in chop
      step(1);
      check({req, " R6 code"}, sw_ctrl, ((j / DIV) % 2 == 0) ? 4'b1010 : 4'b0101);
      check({req, " R7 blank"}, {3'b0, chop_blank}, {3'b0, (j % DIV == 0)});
    end
    alt_sync = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_code, prev;
    int changes;
    step(3);
    // R1
    check("R1 reset code", sw_ctrl, 4'b1010);
    check("R1 reset blank", {3'b0, chop_blank}, 4'b0);
    rst = 1'b0;

    // R2, R3: every fixed encoding, with sync activity that must not matter
    for (int m = 0; m < 8; m++) begin
      if (m == 3 || m == 4) continue;
      mode_sel = 3'(m);
      step(1);
      check("R2 fixed code", sw_ctrl, fixed_code(m));
      for (int k = 0; k < 12; k++) begin
        alt_sync = (k % 4 < 2);
        step(1);
        check("R3 fixed hold", sw_ctrl, fixed_code(m));
        check("R7 blank off", {3'b0, chop_blank}, 4'b0);
      end
      alt_sync = 1'b0;
      step(4);
    end

    // R4: entry into alternate from each fixed code
    for (int m = 0; m < 3; m++) begin
      mode_sel = 3'(m);
      step(2);
      mode_sel = 3'd3;
      step(1);
      check("R4 alt entry", sw_ctrl, 4'b1010);
    end

    // R5, R8: pulses of varied width, exactly one swap each
    exp_code = 4'b1010;
    for (int w = 1; w <= 6; w++) begin
      prev = sw_ctrl;
      changes = 0;
      alt_sync = 1'b1;
      for (int k = 0; k < w + 6; k++) begin
        if (k == w) alt_sync = 1'b0;
        step(1);
        if (sw_ctrl !== prev) changes++;
        prev = sw_ctrl;
        check("R8 no sum", {3'b0, (sw_ctrl == 4'b1100)}, 4'b0);
        check("R7 blank off", {3'b0, chop_blank}, 4'b0);
      end
      exp_code = ~exp_code;
      check("R5 alt code", sw_ctrl, exp_code);
      check("R5 one swap", 4'(changes), 4'd1);
    end
    // R5: latency of the swap
    prev = sw_ctrl;
    alt_sync = 1'b1;
    step(2);
    check("R5 before swap", sw_ctrl, prev);
    step(1);
    check("R5 after swap", sw_ctrl, ~prev);
    alt_sync = 1'b0;
    step(4);

    // R6, R7: chop entered from alternate while showing channel 2
    run_chop(5 * DIV, "R6 first");
    // R9: leave mid-period, return, divider restarts
    mode_sel = 3'd4;
    step(DIV + 3);
    mode_sel = 3'd1;
    step(2);
    check("R9 left chop", sw_ctrl, 4'b0101);
    run_chop(3 * DIV, "R9 reentry");
    mode_sel = 3'd2;
    step(1);
    check("R2 sum after chop", sw_ctrl, 4'b1100);
    check("R7 blank off", {3'b0, chop_blank}, 4'b0);

    // R1: reset from a toggling state
    mode_sel = 3'd3;
    step(2);
    rst = 1'b1;
    step(1);
    check("R1 reset again", sw_ctrl, 4'b1010);
    rst = 1'b0;
    step(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule